// File: doc/BRIEF.md
# Output-Compare Timer With Master Override

This block is an eight-channel output-compare unit built around one shared 16-bit free-running counter. The counter steps by one on every cycle in which `tick_en` is high. Each channel holds a 16-bit compare value and a two-bit pin action. When the counter equals that compare value on a ticking cycle, the channel raises a sticky match flag and applies its action to its pin. Software can also force a channel's pin action through a strobe register. A forced action never raises the flag.

Channel 7 is the master channel. When it fires, every masked channel among 0 to 6 has its pin loaded from a preset data register. This load overrides whatever that channel's own action would have done in the same cycle. A masked compare channel is driven as an output even when the port direction register says input. The direction register itself keeps its value.

Software reaches the block through a single-cycle write port and a combinational read port. The pins, the output enables and the match flags are brought out directly.

Top module: `oct_master_timer`

## Requirements
- R1: After reset the counter, all registers, all match flags, `pin_out` and `pin_oe` are zero.
- R2: The counter (read at address 0x7; writes there are ignored) increases by one after each clock edge at which `tick_en` is 1, holds otherwise, and wraps from 0xFFFF to 0x0000.
- R3: Channel i matches on a clock edge where `tick_en`=1, bit i of the mode register (address 0x0, 1 = compare) is 1, and the counter value before the edge equals compare register i (address 0x8+i). After that edge, flag i (bit i of `match_flags`, also readable at address 0x3) is 1. A channel whose mode bit is 0 never sets its flag and never changes its pin.
- R4: Bits [2i+1:2i] of the action register (address 0x1) give channel i's pin action: 00 leaves the pin alone, 01 inverts it, 10 drives 0, 11 drives 1. The action is applied at the same edge that sets the flag.
- R5: Writing 1 to bit i at address 0x3 clears flag i, and writing 0 leaves it unchanged. If a match and a clear of the same flag fall on the same edge, the flag ends up set.
- R6: Writing 1 to bit i at address 0x2 while channel i is in compare mode applies channel i's pin action at that edge and leaves flag i unchanged.
- R7: When a forced action and a match hit the same channel on the same edge, the pin action is applied once and flag i is not set.
- R8: Reading address 0x2 always returns zero.
- R9: When channel 7 matches or is forced while in compare mode, each channel i in 0..6 whose mask bit i (address 0x4) and mode bit are both 1 has its pin set to bit i of the preset data register (address 0x5). This replaces that channel's own action at the same edge. Bit 7 of the mask and data registers is not stored and reads 0.
- R10: `pin_oe[i]` is bit i of the port direction register (address 0x6) OR'ed, for i in 0..6, with (mask bit i AND mode bit i). The direction register reads back exactly as written.
- R11: Compare register i reads back at address 0x8+i as written, and the action register reads back at address 0x1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_en | input | 1 | Counter advance enable for this cycle |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register write address |
| wr_data | input | 16 | Register write data |
| rd_addr | input | 4 | Register read address |
| rd_data | output | 16 | Register read data (combinational) |
| match_flags | output | 8 | Sticky per-channel match flags |
| pin_out | output | 8 | Channel pin levels |
| pin_oe | output | 8 | Channel pin output enables |

## Verification
The stimulus covers several cases:
- A plain match on each of the toggle, clear and set actions, which separates the action encodings from one another.
- A match on a channel in capture mode, which must leave the pin and flag alone.
- A forced strobe on its own, and a strobe that lands on the very cycle of a match, which tells "forced" apart from "matched" in the flag and catches a double toggle.
- A master match that coincides with a toggle match on a masked channel, with the preset bit chosen opposite to the toggle result, so that override priority becomes visible on the pin.
- A flag clear that coincides with a new match, plus a full counter run through the 0xFFFF wrap.

Throughout, a behavioural reference model is compared against pins, enables, flags and the read port on every cycle.

// File: rtl/oct_pkg.sv
`timescale 1ns/1ps
package oct_pkg;
    localparam int OCT_CH       = 8;
    localparam int OCT_CW       = 16;
    localparam int OCT_CMP_BASE = 8;

    // register addresses
    localparam int A_SEL   = 0;
    localparam int A_ACT   = 1;
    localparam int A_FORCE = 2;
    localparam int A_FLAG  = 3;
    localparam int A_MASK  = 4;
    localparam int A_MDATA = 5;
    localparam int A_PDIR  = 6;
    localparam int A_CNT   = 7;

    typedef enum logic [1:0] {
        PIN_KEEP   = 2'b00,
        PIN_TOGGLE = 2'b01,
        PIN_LOW    = 2'b10,
        PIN_HIGH   = 2'b11
    } pin_act_e;
endpackage

// File: rtl/oct_counter.sv
`timescale 1ns/1ps
module oct_counter #(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    output logic [CW-1:0] cnt
);
    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (tick) begin
            cnt_q <= cnt_q + CW'(1);
        end
    end

    assign cnt = cnt_q;
endmodule

// File: rtl/oct_regs.sv
`timescale 1ns/1ps
module oct_regs #(
    parameter int CH_N  = 8,
    parameter int CNT_W = 16,
    parameter int AW    = 4
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       wr_en,
    input  logic [AW-1:0]              wr_addr,
    input  logic [CNT_W-1:0]           wr_data,
    input  logic [AW-1:0]              rd_addr,
    input  logic [CNT_W-1:0]           cnt,
    input  logic [CH_N-1:0]            flags,
    output logic [CNT_W-1:0]           rd_data,
    output logic [CH_N-1:0]            oc_sel,
    output logic [2*CH_N-1:0]          act,
    output logic [CH_N-1:0]            force_vec,
    output logic [CH_N-1:0]            flag_clr,
    output logic [CH_N-2:0]            mask,
    output logic [CH_N-2:0]            mdata,
    output logic [CH_N-1:0]            pdir,
    output logic [CH_N-1:0][CNT_W-1:0] cmp
);
    import oct_pkg::*;

    localparam int BASE = OCT_CMP_BASE;

    logic [CH_N-1:0]            sel_q;
    logic [2*CH_N-1:0]          act_q;
    logic [CH_N-2:0]            mask_q;
    logic [CH_N-2:0]            mdata_q;
    logic [CH_N-1:0]            pdir_q;
    logic [CH_N-1:0][CNT_W-1:0] cmp_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sel_q   <= '0;
            act_q   <= '0;
            mask_q  <= '0;
            mdata_q <= '0;
            pdir_q  <= '0;
            cmp_q   <= '0;
        end else if (wr_en) begin
            if (wr_addr == AW'(A_SEL))   sel_q   <= wr_data[CH_N-1:0];
            if (wr_addr == AW'(A_ACT))   act_q   <= wr_data[2*CH_N-1:0];
            if (wr_addr == AW'(A_MASK))  mask_q  <= wr_data[CH_N-2:0];
            if (wr_addr == AW'(A_MDATA)) mdata_q <= wr_data[CH_N-2:0];
            if (wr_addr == AW'(A_PDIR))  pdir_q  <= wr_data[CH_N-1:0];
            for (int i = 0; i < CH_N; i++) begin
                if (wr_addr == AW'(BASE + i)) cmp_q[i] <= wr_data;
            end
        end
    end

    // strobes live for the write cycle only; nothing is stored
    assign force_vec = (wr_en && wr_addr == AW'(A_FORCE)) ? wr_data[CH_N-1:0] : '0;
    assign flag_clr  = (wr_en && wr_addr == AW'(A_FLAG))  ? wr_data[CH_N-1:0] : '0;

    always_comb begin
        rd_data = '0;
        if (rd_addr == AW'(A_SEL))   rd_data = CNT_W'(sel_q);
        if (rd_addr == AW'(A_ACT))   rd_data = CNT_W'(act_q);
        if (rd_addr == AW'(A_FLAG))  rd_data = CNT_W'(flags);
        if (rd_addr == AW'(A_MASK))  rd_data = CNT_W'(mask_q);
        if (rd_addr == AW'(A_MDATA)) rd_data = CNT_W'(mdata_q);
        if (rd_addr == AW'(A_PDIR))  rd_data = CNT_W'(pdir_q);
        if (rd_addr == AW'(A_CNT))   rd_data = cnt;
        for (int i = 0; i < CH_N; i++) begin
            if (rd_addr == AW'(BASE + i)) rd_data = cmp_q[i];
        end
    end

    assign oc_sel = sel_q;
    assign act    = act_q;
    assign mask   = mask_q;
    assign mdata  = mdata_q;
    assign pdir   = pdir_q;
    assign cmp    = cmp_q;
endmodule

// File: rtl/oct_channel.sv
`timescale 1ns/1ps
module oct_channel #(
    parameter int CW = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic [CW-1:0]    cnt,
    input  logic [CW-1:0]    cmp,
    input  logic             oc_on,
    input  oct_pkg::pin_act_e act,
    input  logic             force_i,
    input  logic             ovr_en,
    input  logic             ovr_val,
    input  logic             flag_clr,
    output logic             flag,
    output logic             pin
);
    import oct_pkg::*;

    logic hit, fire, pin_q, pin_d, flag_q;

    assign hit  = oc_on && tick && (cnt == cmp);
    assign fire = oc_on && (hit || force_i);

    // master override ranks above the channel's own action
    always_comb begin
        pin_d = pin_q;
        if (ovr_en && oc_on) begin
            pin_d = ovr_val;
        end else if (fire) begin
            unique case (act)
                PIN_KEEP:   pin_d = pin_q;
                PIN_TOGGLE: pin_d = ~pin_q;
                PIN_LOW:    pin_d = 1'b0;
                PIN_HIGH:   pin_d = 1'b1;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pin_q  <= 1'b0;
            flag_q <= 1'b0;
        end else begin
            pin_q  <= pin_d;
            flag_q <= (flag_q & ~flag_clr) | (hit & ~force_i);
        end
    end

    assign flag = flag_q;
    assign pin  = pin_q;
endmodule

// File: rtl/oct_master_timer.sv
`timescale 1ns/1ps
module oct_master_timer #(
    parameter int CH_N  = oct_pkg::OCT_CH,
    parameter int CNT_W = oct_pkg::OCT_CW,
    localparam int AW   = $clog2(oct_pkg::OCT_CMP_BASE + CH_N)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_en,
    input  logic             wr_en,
    input  logic [AW-1:0]    wr_addr,
    input  logic [CNT_W-1:0] wr_data,
    input  logic [AW-1:0]    rd_addr,
    output logic [CNT_W-1:0] rd_data,
    output logic [CH_N-1:0]  match_flags,
    output logic [CH_N-1:0]  pin_out,
    output logic [CH_N-1:0]  pin_oe
);
    import oct_pkg::*;

    localparam int MST = CH_N - 1;

    logic [CNT_W-1:0]           cnt_q;
    logic [CH_N-1:0]            oc_sel_q;
    logic [2*CH_N-1:0]          act_q;
    logic [CH_N-1:0]            force_vec;
    logic [CH_N-1:0]            flag_clr;
    logic [CH_N-2:0]            mask_q;
    logic [CH_N-2:0]            mdata_q;
    logic [CH_N-1:0]            pdir_q;
    logic [CH_N-1:0][CNT_W-1:0] cmp_q;
    logic                       master_evt;

    oct_counter #(.CW(CNT_W)) u_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (tick_en),
        .cnt   (cnt_q)
    );

    oct_regs #(.CH_N(CH_N), .CNT_W(CNT_W), .AW(AW)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .rd_addr   (rd_addr),
        .cnt       (cnt_q),
        .flags     (match_flags),
        .rd_data   (rd_data),
        .oc_sel    (oc_sel_q),
        .act       (act_q),
        .force_vec (force_vec),
        .flag_clr  (flag_clr),
        .mask      (mask_q),
        .mdata     (mdata_q),
        .pdir      (pdir_q),
        .cmp       (cmp_q)
    );

    // master channel fires on its own match or on its force strobe
    assign master_evt = oc_sel_q[MST] &
                        ((tick_en & (cnt_q == cmp_q[MST])) | force_vec[MST]);

    for (genvar g = 0; g < CH_N; g++) begin : g_ch
        logic ovr, ovr_val;
        if (g < MST) begin : g_slave
            assign ovr     = master_evt & mask_q[g];
            assign ovr_val = mdata_q[g];
        end else begin : g_master
            assign ovr     = 1'b0;
            assign ovr_val = 1'b0;
        end

        oct_channel #(.CW(CNT_W)) u_ch (
            .clk      (clk),
            .rst_n    (rst_n),
            .tick     (tick_en),
            .cnt      (cnt_q),
            .cmp      (cmp_q[g]),
            .oc_on    (oc_sel_q[g]),
            .act      (pin_act_e'(act_q[2*g +: 2])),
            .force_i  (force_vec[g]),
            .ovr_en   (ovr),
            .ovr_val  (ovr_val),
            .flag_clr (flag_clr[g]),
            .flag     (match_flags[g]),
            .pin      (pin_out[g])
        );
    end

    assign pin_oe = pdir_q | {1'b0, mask_q & oc_sel_q[CH_N-2:0]};
endmodule

// File: rtl/oct_master_timer_chk.sv
`timescale 1ns/1ps
module oct_master_timer_chk #(
    parameter int CH_N  = 8,
    parameter int CNT_W = 16,
    parameter int AW    = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             tick_en,
    input logic [AW-1:0]    rd_addr,
    input logic [CNT_W-1:0] rd_data,
    input logic [CH_N-1:0]  match_flags,
    input logic [CH_N-1:0]  pin_out,
    input logic [CNT_W-1:0] cnt_q,
    input logic [CH_N-1:0]  force_vec,
    input logic             master_evt,
    input logic [CH_N-2:0]  mask_q,
    input logic [CH_N-2:0]  mdata_q,
    input logic [CH_N-1:0]  oc_sel_q
);
    assert_force_reads_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
        rd_addr == AW'(oct_pkg::A_FORCE) |-> rd_data == '0);

    assert_counter_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        tick_en |=> cnt_q == $past(cnt_q) + CNT_W'(1));

    assert_counter_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !tick_en |=> $stable(cnt_q));

    for (genvar g = 0; g < CH_N; g++) begin : g_flag
        assert_force_no_flag_R6: assert property (@(posedge clk) disable iff (!rst_n)
            force_vec[g] && !match_flags[g] |=> !match_flags[g]);

        assert_capture_no_flag_R3: assert property (@(posedge clk) disable iff (!rst_n)
            !oc_sel_q[g] && !match_flags[g] |=> !match_flags[g]);
    end

    for (genvar g = 0; g < CH_N - 1; g++) begin : g_ovr
        assert_master_drive_R9: assert property (@(posedge clk) disable iff (!rst_n)
            master_evt && mask_q[g] && oc_sel_q[g] |=> pin_out[g] == $past(mdata_q[g]));
    end
endmodule

bind oct_master_timer oct_master_timer_chk chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .tick_en     (tick_en),
    .rd_addr     (rd_addr),
    .rd_data     (rd_data),
    .match_flags (match_flags),
    .pin_out     (pin_out),
    .cnt_q       (cnt_q),
    .force_vec   (force_vec),
    .master_evt  (master_evt),
    .mask_q      (mask_q),
    .mdata_q     (mdata_q),
    .oc_sel_q    (oc_sel_q)
);

// File: tb/oct_master_timer_tb.sv
`timescale 1ns/1ps
module oct_master_timer_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick_en = 1'b0;
    logic        wr_en = 1'b0;
    logic [3:0]  wr_addr = '0;
    logic [15:0] wr_data = '0;
    logic [3:0]  rd_addr = '0;
    logic [15:0] rd_data;
    logic [7:0]  match_flags, pin_out, pin_oe;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    oct_master_timer dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .tick_en     (tick_en),
        .wr_en       (wr_en),
        .wr_addr     (wr_addr),
        .wr_data     (wr_data),
        .rd_addr     (rd_addr),
        .rd_data     (rd_data),
        .match_flags (match_flags),
        .pin_out     (pin_out),
        .pin_oe      (pin_oe)
    );

    // ---------------- behavioural reference model ----------------
    int unsigned m_cnt;
    bit [7:0]    m_sel, m_flag, m_pin, m_pdir;
    bit [15:0]   m_act;
    bit [6:0]    m_mask, m_md;
    bit [15:0]   m_cmp [8];
    bit [7:0]    t_hit, t_frc, t_clr, t_np;
    bit          t_mst;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_cnt = 0; m_sel = 0; m_flag = 0; m_pin = 0; m_pdir = 0;
            m_act = 0; m_mask = 0; m_md = 0;
            for (int i = 0; i < 8; i++) m_cmp[i] = 0;
        end else begin
            t_frc = (wr_en && wr_addr == 4'd2) ? (wr_data[7:0] & m_sel) : 8'h00;
            t_clr = (wr_en && wr_addr == 4'd3) ? wr_data[7:0] : 8'h00;
            for (int i = 0; i < 8; i++)
                t_hit[i] = tick_en && m_sel[i] && (m_cnt == int'(m_cmp[i]));
            t_mst = t_hit[7] | t_frc[7];
            t_np = m_pin;
            for (int i = 0; i < 8; i++) begin
                if (i < 7 && t_mst && m_mask[i] && m_sel[i]) t_np[i] = m_md[i];
                else if (t_hit[i] || t_frc[i]) begin
                    case (m_act[2*i +: 2])
                        2'b01: t_np[i] = ~m_pin[i];
                        2'b10: t_np[i] = 1'b0;
                        2'b11: t_np[i] = 1'b1;
                        default: ;
                    endcase
                end
            end
            m_pin  = t_np;
            m_flag = (m_flag & ~t_clr) | (t_hit & ~t_frc);
            if (tick_en) m_cnt = (m_cnt + 1) % 65536;
            if (wr_en) begin
                case (wr_addr)
                    4'd0: m_sel  = wr_data[7:0];
                    4'd1: m_act  = wr_data;
                    4'd4: m_mask = wr_data[6:0];
                    4'd5: m_md   = wr_data[6:0];
                    4'd6: m_pdir = wr_data[7:0];
                    default: if (wr_addr >= 4'd8) m_cmp[wr_addr - 4'd8] = wr_data;
                endcase
            end
        end
    end

    function automatic logic [15:0] model_rd(input logic [3:0] a);
        case (a)
            4'd0: return {8'h00, m_sel};
            4'd1: return m_act;
            4'd3: return {8'h00, m_flag};
            4'd4: return {9'h000, m_mask};
            4'd5: return {9'h000, m_md};
            4'd6: return {8'h00, m_pdir};
            4'd7: return m_cnt[15:0];
            4'd2: return 16'h0000;
            default: return m_cmp[a - 4'd8];
        endcase
    endfunction

    // per-cycle comparison, sampled 1 ns after the edge
    always @(posedge clk) begin
        #1;
        if (rst_n) begin
            checks++;
            if (pin_out !== m_pin || match_flags !== m_flag ||
                pin_oe !== (m_pdir | {1'b0, m_mask & m_sel[6:0]}) ||
                rd_data !== model_rd(rd_addr)) begin
                errors++;
                $display("FAIL model R3/R4/R9/R10 pins=%h/%h flags=%h/%h oe=%h/%h rd=%h/%h (actual/expected)",
                         pin_out, m_pin, match_flags, m_flag, pin_oe,
                         m_pdir | {1'b0, m_mask & m_sel[6:0]}, rd_data, model_rd(rd_addr));
            end
        end
    end

    // ---------------- helpers ----------------
    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic rdchk(input string req, input logic [3:0] a, input logic [15:0] exp);
        rd_addr = a;
        #1;
        chk(req, rd_data, exp);
    endtask

    task automatic wr(input logic [3:0] a, input logic [15:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic cyc(input logic t, input logic [3:0] a, input logic [15:0] d);
        @(negedge clk);
        tick_en = t; wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        tick_en = 1'b0; wr_en = 1'b0;
    endtask

    task automatic ticks(input int n);
        @(negedge clk);
        tick_en = 1'b1;
        repeat (n) @(negedge clk);
        tick_en = 1'b0;
    endtask

    // ---------------- directed sequence ----------------
    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 pins", {8'h00, pin_out}, 16'h0000);
        chk("R1 flags", {8'h00, match_flags}, 16'h0000);
        chk("R1 oe", {8'h00, pin_oe}, 16'h0000);
        rdchk("R1 counter", 4'd7, 16'h0000);
        rdchk("R1 action", 4'd1, 16'h0000);

        wr(4'd0, 16'h00FF);
        wr(4'd1, 16'hD539);
        for (int i = 0; i < 8; i++) wr(4'(8 + i), 16'hF000 + 16'(i));

        // R6 force without flag
        wr(4'd2, 16'h0005);
        chk("R6 force pins", {8'h00, pin_out}, 16'h0005);
        chk("R6 force flags", {8'h00, match_flags}, 16'h0000);
        rdchk("R8 force reads zero", 4'd2, 16'h0000);
        wr(4'd2, 16'h0001);

        // R3/R4 toggle on match
        wr(4'd8, 16'd3);
        ticks(4);
        chk("R4 toggle pins", {8'h00, pin_out}, 16'h0005);
        chk("R3 match flag", {8'h00, match_flags}, 16'h0001);

        // R5 clear
        wr(4'd3, 16'h0000);
        chk("R5 zero write keeps", {8'h00, match_flags}, 16'h0001);
        wr(4'd3, 16'h0001);
        chk("R5 clear", {8'h00, match_flags}, 16'h0000);

        // R3 capture-mode channel ignored
        wr(4'd0, 16'h00FE);
        wr(4'd8, 16'd6);
        ticks(3);
        chk("R3 capture pins", {8'h00, pin_out}, 16'h0005);
        chk("R3 capture flags", {8'h00, match_flags}, 16'h0000);
        wr(4'd0, 16'h00FF);

        // R7 force with match
        wr(4'd12, 16'd7);
        cyc(1'b1, 4'd2, 16'h0010);
        chk("R7 single toggle", {8'h00, pin_out}, 16'h0015);
        chk("R7 flag clear", {8'h00, match_flags}, 16'h0000);

        // R9 master override beats toggle
        wr(4'd4, 16'h0003);
        wr(4'd5, 16'h0003);
        wr(4'd15, 16'd10);
        wr(4'd8, 16'd10);
        ticks(3);
        chk("R9 override pins", {8'h00, pin_out}, 16'h0097);
        chk("R9 flags", {8'h00, match_flags}, 16'h0081);
        chk("R10 masked oe", {8'h00, pin_oe}, 16'h0003);
        wr(4'd3, 16'h00FF);

        // R4 clear action
        wr(4'd9, 16'd12);
        ticks(2);
        chk("R4 clear pins", {8'h00, pin_out}, 16'h0095);
        chk("R4 clear flag", {8'h00, match_flags}, 16'h0002);

        // R10 direction
        wr(4'd6, 16'h0040);
        chk("R10 oe", {8'h00, pin_oe}, 16'h0043);
        rdchk("R10 dir read", 4'd6, 16'h0040);
        wr(4'd0, 16'h00FD);
        chk("R10 oe sel off", {8'h00, pin_oe}, 16'h0041);
        rdchk("R10 dir kept", 4'd6, 16'h0040);
        wr(4'd0, 16'h00FF);

        // R9 mask bit 7 not stored, forced master
        wr(4'd4, 16'h00FF);
        rdchk("R9 mask read", 4'd4, 16'h007F);
        wr(4'd2, 16'h0080);
        chk("R9 forced master pins", {8'h00, pin_out}, 16'h0083);
        chk("R6 forced master flags", {8'h00, match_flags}, 16'h0002);

        // R5 set wins over clear
        wr(4'd13, 16'd13);
        cyc(1'b1, 4'd3, 16'h0020);
        chk("R5 set wins", {8'h00, match_flags}, 16'h0022);
        chk("R4 toggle ch5", {8'h00, pin_out}, 16'h00A3);

        // R11 readback, R2 counter
        rdchk("R11 cmp5", 4'd13, 16'h000D);
        rdchk("R11 action", 4'd1, 16'hD539);
        rdchk("R2 counter", 4'd7, 16'h000E);
        wr(4'd7, 16'h1234);
        rdchk("R2 counter write ignored", 4'd7, 16'h000E);
        ticks(65521);
        rdchk("R2 counter top", 4'd7, 16'hFFFF);
        ticks(1);
        rdchk("R2 wrap", 4'd7, 16'h0000);

        repeat (3) @(negedge clk);
        if (!done) begin
            done = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            errors++;
            checks++;
            $display("FAIL watchdog R2 actual=timeout expected=finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule